// File: doc/BRIEF.md
# Serial Port with Line Override and Sticky Receive Errors

This block is a byte-wide serial port. It sends and receives asynchronous frames on a transmit and a receive line, and it can also work in a clock-synchronous mode in which it drives a serial clock for each byte. Bytes enter through a valid/ready transmit stream and leave through a valid/ready receive stream. The receiver records overrun, framing and parity faults in three sticky flags. Software clears a flag by writing 0 to its bit. A pin-override control lets software take the transmit line away from the serializer at any moment. Software uses it to hold the line high before transmitting, or to drive a break (a low line) in the middle of a frame.

Back-pressure rules: a byte is taken on `tx_data` in a cycle where both `tx_valid` and `tx_ready` are high. `tx_ready` is high exactly when the one-byte holding register is empty. A received byte on `rx_data` stays stable while `rx_valid` is high and `rx_ready` is low. If a new frame completes in that state, the new byte is dropped and the overrun flag is raised. All control inputs are plain levels. One bit lasts 16 ticks of a divider that produces a tick every `DIV` clock cycles.

Top module: `sio_port`

## Requirements
- R1: An asynchronous frame on `txd` is a 0 start bit, then 8 data bits with the least significant bit first, then a parity bit when `par_en` is 1 (the XOR of the data bits, XORed with `par_odd`), then a 1 stop bit. Each bit lasts 16*DIV cycles.
- R2: When `pin_ovr` is 0 and no frame is being shifted out, `txd` is 1. `sclk` is 1 whenever no synchronous byte is in progress.
- R3: When `pin_ovr` is 1 and `pin_dir` is 1, `txd` equals `pin_dat` and `txd_oe` is 1 in the same cycle, even in the middle of a frame. When `pin_ovr` is 1 and `pin_dir` is 0, `txd_oe` is 0. When `pin_ovr` is 0, `txd_oe` is 1.
- R4: `tx_ready` is 1 exactly when the holding register is empty. A held byte is not sent while `tx_en` is 0.
- R5: A received asynchronous frame delivers its 8 data bits on `rx_data` with `rx_valid` high. Both stay stable until `rx_ready` is seen high.
- R6: If the stop bit is sampled as 0, err_flags[1] (framing) is set. While the receive line is held low (a break), reception continues, so the framing flag is set again after software clears it.
- R7: If parity is enabled and the received parity bit differs from the expected value, err_flags[2] is set.
- R8: If a frame completes while `rx_valid` is 1 and `rx_ready` is 0, err_flags[0] (overrun) is set and the held byte is kept.
- R9: In a cycle where `err_wr` is 1, each flag whose `err_wdata` bit is 0 is cleared, and each flag whose bit is 1 is left unchanged. An error raised in the same cycle wins over the clear. Flags never fall without such a write.
- R10: Setting `rx_en` to 0 leaves the error flags as they are. While `rx_en` is 0, frames on `rxd` produce no output.
- R11: In synchronous mode a byte is shifted out least significant bit first. `sclk` is low for the first half of each bit and high for the second half. `rxd` is sampled at each rising edge of `sclk`, and after the eighth bit the assembled byte appears on `rx_data`.
- R12: In synchronous mode no new byte starts while any error flag is 1. The held byte starts once the flags are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| sync_mode | input | 1 | 1 selects clock-synchronous mode |
| par_en | input | 1 | Parity bit present in asynchronous frames |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| pin_ovr | input | 1 | Transmit line taken over by the port controls |
| pin_dir | input | 1 | Port direction while overridden (1 = drive) |
| pin_dat | input | 1 | Port level while overridden |
| err_wr | input | 1 | Write strobe for the error flags |
| err_wdata | input | 3 | Write data; a 0 bit clears the matching flag |
| err_flags | output | 3 | {parity, framing, overrun} error flags |
| tx_valid | input | 1 | Transmit byte valid |
| tx_ready | output | 1 | Holding register empty |
| tx_data | input | 8 | Transmit byte |
| rx_valid | output | 1 | Received byte valid |
| rx_ready | input | 1 | Consumer takes the received byte |
| rx_data | output | 8 | Received byte |
| txd | output | 1 | Transmit line |
| txd_oe | output | 1 | Transmit line output enable |
| rxd | input | 1 | Receive line |
| sclk | output | 1 | Serial clock in synchronous mode |

## Verification
A transmit counter that has slipped shows up on `txd` within one bit time: parity, stop or data values land at the wrong sample points in the first frame. A receiver that drops a flag, or clears one without a write, shows on `err_flags` within one frame of the fault or the write. A stuck gating path shows as `sclk` toggling while a flag is set. Override faults are visible combinationally, in the same cycle the controls change.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int OSR  = 16;
  localparam int SUBW = $clog2(OSR);
  localparam int ERRW = 3;

  typedef struct packed {
    logic par;
    logic frm;
    logic ovr;
  } err_t;
endpackage

// File: rtl/sio_baud.sv
module sio_baud #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt;

  assign tick = (cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sio_tx.sv
module sio_tx
  import sio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       tx_en,
  input  logic       sync_mode,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       blocked,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       line,
  output logic       sclk,
  output logic       busy,
  output logic       samp,
  output logic       samp_last
);
  logic            full, msync;
  logic [7:0]      hold;
  logic [10:0]     sreg;
  logic [SUBW-1:0] sub;
  logic [3:0]      idx, last;
  logic            start, pbit;

  assign in_ready  = !full;
  assign pbit      = (^hold) ^ par_odd;
  assign start     = !busy && full && tx_en && tick && !(sync_mode && blocked);
  assign line      = busy ? sreg[0] : 1'b1;
  assign sclk      = !(busy && msync && (sub < SUBW'(OSR / 2)));
  assign samp      = busy && msync && tick && (sub == SUBW'(OSR / 2 - 1));
  assign samp_last = (idx == last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full  <= 1'b0;
      hold  <= '0;
      busy  <= 1'b0;
      msync <= 1'b0;
      sreg  <= '1;
      sub   <= '0;
      idx   <= '0;
      last  <= '0;
    end else begin
      if (in_valid && !full) begin
        full <= 1'b1;
        hold <= in_data;
      end
      if (start) begin
        full  <= 1'b0;
        busy  <= 1'b1;
        sub   <= '0;
        idx   <= '0;
        msync <= sync_mode;
        if (sync_mode) begin
          sreg <= {3'b111, hold};
          last <= 4'd7;
        end else if (par_en) begin
          sreg <= {1'b1, pbit, hold, 1'b0};
          last <= 4'd10;
        end else begin
          sreg <= {2'b11, hold, 1'b0};
          last <= 4'd9;
        end
      end else if (busy && tick) begin
        if (sub == SUBW'(OSR - 1)) begin
          sub  <= '0;
          sreg <= {1'b1, sreg[10:1]};
          idx  <= idx + 4'd1;
          if (idx == last) busy <= 1'b0;
        end else begin
          sub <= sub + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sio_rx.sv
module sio_rx
  import sio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rx_en,
  input  logic       sync_mode,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       rxd_s,
  input  logic       s_samp,
  input  logic       s_last,
  input  logic       out_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  output err_t       err_set
);
  logic            busy, pbit, mid, a_done, s_done, fin, occupied;
  logic [SUBW-1:0] sub;
  logic [3:0]      idx, stop_idx;
  logic [7:0]      sh, fin_data;

  always_comb begin
    stop_idx    = par_en ? 4'd10 : 4'd9;
    mid         = busy && !sync_mode && tick && (sub == SUBW'(OSR / 2 - 1));
    a_done      = mid && (idx == stop_idx);
    s_done      = sync_mode && rx_en && s_samp && s_last;
    fin         = a_done || s_done;
    fin_data    = sync_mode ? {rxd_s, sh[7:1]} : sh;
    occupied    = out_valid && !out_ready;
    err_set.ovr = fin && occupied;
    err_set.frm = a_done && !rxd_s;
    err_set.par = a_done && par_en && (pbit != ((^sh) ^ par_odd));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      sub       <= '0;
      idx       <= '0;
      sh        <= '0;
      pbit      <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (fin && !occupied) begin
        out_valid <= 1'b1;
        out_data  <= fin_data;
      end
      if (sync_mode && rx_en && s_samp) sh <= {rxd_s, sh[7:1]};
      if (!rx_en || sync_mode) begin
        busy <= 1'b0;
      end else if (!busy) begin
        if (tick && !rxd_s) begin
          busy <= 1'b1;
          sub  <= '0;
          idx  <= '0;
        end
      end else if (tick) begin
        sub <= sub + 1'b1;
        if (sub == SUBW'(OSR / 2 - 1)) begin
          idx <= idx + 4'd1;
          if (idx == 4'd0 && rxd_s)           busy <= 1'b0;
          else if (idx >= 4'd1 && idx <= 4'd8) sh  <= {rxd_s, sh[7:1]};
          else if (idx == 4'd9 && par_en)      pbit <= rxd_s;
          if (idx == stop_idx) busy <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/sio_port.sv
module sio_port
  import sio_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tx_en,
  input  logic            rx_en,
  input  logic            sync_mode,
  input  logic            par_en,
  input  logic            par_odd,
  input  logic            pin_ovr,
  input  logic            pin_dir,
  input  logic            pin_dat,
  input  logic            err_wr,
  input  logic [ERRW-1:0] err_wdata,
  output logic [ERRW-1:0] err_flags,
  input  logic            tx_valid,
  output logic            tx_ready,
  input  logic [7:0]      tx_data,
  output logic            rx_valid,
  input  logic            rx_ready,
  output logic [7:0]      rx_data,
  output logic            txd,
  output logic            txd_oe,
  input  logic            rxd,
  output logic            sclk
);
  logic tick, line, tx_busy, samp, samp_last, rxd_m, rxd_s;
  err_t err_q, err_set;

  sio_baud #(.DIV(DIV)) u_baud (.clk(clk), .rst_n(rst_n), .tick(tick));

  sio_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tx_en(tx_en), .sync_mode(sync_mode),
    .par_en(par_en), .par_odd(par_odd), .blocked(|err_q), .in_valid(tx_valid),
    .in_data(tx_data), .in_ready(tx_ready), .line(line), .sclk(sclk),
    .busy(tx_busy), .samp(samp), .samp_last(samp_last)
  );

  sio_rx u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx_en(rx_en), .sync_mode(sync_mode),
    .par_en(par_en), .par_odd(par_odd), .rxd_s(rxd_s), .s_samp(samp),
    .s_last(samp_last), .out_ready(rx_ready), .out_valid(rx_valid),
    .out_data(rx_data), .err_set(err_set)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxd_m <= 1'b1;
      rxd_s <= 1'b1;
      err_q <= '0;
    end else begin
      rxd_m <= rxd;
      rxd_s <= rxd_m;
      err_q <= (err_wr ? (err_q & err_t'(err_wdata)) : err_q) | err_set;
    end
  end

  assign err_flags = err_q;
  assign txd       = pin_ovr ? (pin_dir ? pin_dat : 1'b1) : line;
  assign txd_oe    = !pin_ovr || pin_dir;
endmodule

// File: rtl/sio_port_chk.sv
module sio_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pin_ovr,
  input logic       pin_dir,
  input logic       pin_dat,
  input logic       txd,
  input logic       txd_oe,
  input logic       sclk,
  input logic       tx_busy,
  input logic       sync_mode,
  input logic [2:0] err_flags,
  input logic       err_wr,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [7:0] rx_data
);
  p_override_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_ovr && pin_dir) |-> (txd == pin_dat) && txd_oe);

  p_override_float_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_ovr && !pin_dir) |-> !txd_oe);

  p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pin_ovr && !tx_busy) |-> txd && sclk);

  p_sticky_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !err_wr |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

  p_sync_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && (|err_flags) && !tx_busy) |=> !tx_busy);

  p_rx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> rx_valid && $stable(rx_data));
endmodule

bind sio_port sio_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pin_ovr(pin_ovr), .pin_dir(pin_dir),
  .pin_dat(pin_dat), .txd(txd), .txd_oe(txd_oe), .sclk(sclk),
  .tx_busy(tx_busy), .sync_mode(sync_mode), .err_flags(err_flags),
  .err_wr(err_wr), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data)
);

// File: tb/sio_port_bench.sv
module sio_port_bench;
  localparam int DIV = 2;
  localparam int BIT = 16 * DIV;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_en = 0, rx_en = 0, sync_mode = 0, par_en = 0, par_odd = 0;
  logic pin_ovr = 0, pin_dir = 0, pin_dat = 0, err_wr = 0;
  logic [2:0] err_wdata = '1, err_flags;
  logic tx_valid = 0, tx_ready, rx_valid, rx_ready = 1, txd, txd_oe, rxd = 1, sclk;
  logic [7:0] tx_data = '0, rx_data;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sio_port #(.DIV(DIV)) u_sio_port (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en), .sync_mode(sync_mode),
    .par_en(par_en), .par_odd(par_odd), .pin_ovr(pin_ovr), .pin_dir(pin_dir),
    .pin_dat(pin_dat), .err_wr(err_wr), .err_wdata(err_wdata), .err_flags(err_flags),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .txd(txd), .txd_oe(txd_oe), .rxd(rxd),
    .sclk(sclk)
  );

  function automatic logic exp_par(input logic [7:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_tx(input logic [7:0] d);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_data = d; tx_valid = 1;
    @(negedge clk);
    tx_valid = 0;
  endtask

  task automatic cap_async(input logic pe, output logic [7:0] d, output logic p,
                           output logic st, output logic sp);
    do @(negedge clk); while (txd !== 1'b0);
    wait_cyc(BIT / 2);
    st = txd;
    for (int i = 0; i < 8; i++) begin wait_cyc(BIT); d[i] = txd; end
    p = 1'b0;
    if (pe) begin wait_cyc(BIT); p = txd; end
    wait_cyc(BIT);
    sp = txd;
  endtask

  task automatic send_rx(input logic [7:0] d, input logic pe, input logic odd,
                         input logic flip, input logic stopv);
    @(negedge clk);
    rxd = 0; wait_cyc(BIT);
    for (int i = 0; i < 8; i++) begin rxd = d[i]; wait_cyc(BIT); end
    if (pe) begin rxd = exp_par(d, odd) ^ flip; wait_cyc(BIT); end
    rxd = stopv;
    wait_cyc(stopv ? BIT : (BIT * 3) / 4);
    rxd = 1; wait_cyc(BIT);
  endtask

  task automatic write_err(input logic [2:0] v);
    @(negedge clk);
    err_wr = 1; err_wdata = v;
    @(negedge clk);
    err_wr = 0; err_wdata = '1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, got, e;
    logic p, st, sp, pe, odd;
    int lows;
    void'($urandom(32'd4711));
    wait_cyc(5); rst_n = 1; wait_cyc(2);

    // reset state
    chk("R4", "reset tx_ready", int'(tx_ready), 1);
    chk("R5", "reset rx_valid", int'(rx_valid), 0);
    chk("R9", "reset flags", int'(err_flags), 0);
    chk("R2", "reset txd", int'(txd), 1);
    chk("R2", "reset sclk", int'(sclk), 1);
    chk("R3", "reset txd_oe", int'(txd_oe), 1);

    // R4: held byte waits for tx_en
    push_tx(8'hA5);
    lows = 0;
    for (int i = 0; i < 12 * BIT; i++) begin @(negedge clk); if (!txd) lows++; end
    chk("R4", "no send without tx_en", lows, 0);
    chk("R4", "holding full", int'(tx_ready), 0);
    tx_en = 1;
    cap_async(0, got, p, st, sp);
    chk("R1", "first byte", int'(got), 8'hA5);
    chk("R1", "stop bit", int'(sp), 1);

    // R1: random async transmit
    for (int n = 0; n < 6; n++) begin
      pe = 1'($urandom); odd = 1'($urandom); d = 8'($urandom);
      wait_cyc(BIT);
      par_en = pe; par_odd = odd;
      push_tx(d);
      cap_async(pe, got, p, st, sp);
      chk("R1", "start", int'(st), 0);
      chk("R1", "data", int'(got), int'(d));
      if (pe) chk("R1", "parity", int'(p), int'(exp_par(d, odd)));
      chk("R1", "stop", int'(sp), 1);
    end
    wait_cyc(BIT);
    chk("R2", "idle txd", int'(txd), 1);

    // R5: random async receive
    rx_en = 1; rx_ready = 1;
    for (int n = 0; n < 6; n++) begin
      pe = 1'($urandom); odd = 1'($urandom); d = 8'($urandom);
      par_en = pe; par_odd = odd;
      send_rx(d, pe, odd, 0, 1);
      chk("R5", "rx data", int'(rx_data), int'(d));
      chk("R5", "no error", int'(err_flags), 0);
    end

    // R7 parity error, R9 write semantics
    par_en = 1; par_odd = 0;
    send_rx(8'h3C, 1, 0, 1, 1);
    chk("R7", "parity flag", int'(err_flags), 3'b100);
    write_err(3'b111);
    chk("R9", "write ones no effect", int'(err_flags), 3'b100);
    write_err(3'b011);
    chk("R9", "write zero clears", int'(err_flags), 0);

    // R6 framing error, R10 disable keeps flags
    par_en = 0;
    send_rx(8'h81, 0, 0, 0, 0);
    chk("R6", "framing flag", int'(err_flags), 3'b010);
    rx_en = 0; rx_ready = 0;
    wait_cyc(4);
    chk("R10", "flags survive rx_en=0", int'(err_flags), 3'b010);
    send_rx(8'h5A, 0, 0, 0, 1);
    chk("R10", "no output while disabled", int'(rx_valid), 0);
    chk("R10", "flags unchanged", int'(err_flags), 3'b010);
    rx_en = 1; rx_ready = 1;

    // R12 sync gating with framing flag pending
    sync_mode = 1;
    e = 8'h96;
    rxd = e[0];
    push_tx(8'hC3);
    lows = 0;
    for (int i = 0; i < 10 * BIT; i++) begin @(negedge clk); if (!sclk) lows++; end
    chk("R12", "no sclk while flagged", lows, 0);
    chk("R12", "byte still held", int'(tx_ready), 0);
    write_err(3'b000);

    // R11 sync transfer
    for (int i = 0; i < 8; i++) begin
      do @(negedge clk); while (sclk !== 1'b0);
      do @(negedge clk); while (sclk !== 1'b1);
      got[i] = txd;
      if (i < 7) rxd = e[i + 1];
    end
    wait_cyc(4);
    chk("R11", "sync tx byte", int'(got), 8'hC3);
    chk("R11", "sync rx byte", int'(rx_data), int'(e));
    chk("R12", "flags clear", int'(err_flags), 0);
    wait_cyc(BIT); rxd = 1; sync_mode = 0; wait_cyc(2 * BIT);

    // R6 break: flag comes back after clear
    rxd = 0;
    for (int k = 0; k < 2; k++) begin
      do @(negedge clk); while (!rx_valid);
    end
    chk("R6", "break sets framing", int'(err_flags[1]), 1);
    wait_cyc(4);
    write_err(3'b000);
    chk("R6", "cleared during break", int'(err_flags), 0);
    do @(negedge clk); while (!rx_valid);
    chk("R6", "framing set again", int'(err_flags[1]), 1);
    rxd = 1; wait_cyc(14 * BIT);
    write_err(3'b000);
    chk("R9", "clear after break", int'(err_flags), 0);

    // R8 overrun
    rx_ready = 0;
    send_rx(8'h11, 0, 0, 0, 1);
    chk("R8", "first byte held", int'(rx_data), 8'h11);
    chk("R5", "valid held", int'(rx_valid), 1);
    send_rx(8'h22, 0, 0, 0, 1);
    chk("R8", "overrun flag", int'(err_flags), 3'b001);
    chk("R8", "old byte kept", int'(rx_data), 8'h11);
    @(negedge clk); rx_ready = 1; @(negedge clk);
    chk("R5", "valid drops after take", int'(rx_valid), 0);
    write_err(3'b110);
    chk("R9", "overrun cleared", int'(err_flags), 0);

    // R3 override mid-frame
    push_tx(8'hFF);
    do @(negedge clk); while (txd !== 1'b0);
    wait_cyc(3 * BIT);
    pin_ovr = 1; pin_dir = 1; pin_dat = 0;
    #1;
    chk("R3", "break forced", int'(txd), 0);
    chk("R3", "driven", int'(txd_oe), 1);
    wait_cyc(2 * BIT);
    chk("R3", "break held", int'(txd), 0);
    pin_dat = 1; #1;
    chk("R3", "mark forced", int'(txd), 1);
    pin_dir = 0; #1;
    chk("R3", "float", int'(txd_oe), 0);
    pin_dir = 1;
    wait_cyc(12 * BIT);
    pin_ovr = 0; #1;
    chk("R2", "idle after override", int'(txd), 1);
    chk("R3", "oe back", int'(txd_oe), 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule